// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts hardware events for profiling. It holds three 32-bit counters: a cycle counter that advances with the clock, and two event counters (counter 0 and counter 1) that each follow one line of an event pulse vector. Each event counter picks its line with an 8-bit selector. All counting is gated by one global enable. One packed control word holds that enable, a cycle-counter slow-down option, self-clearing zeroing commands, the two selectors, per-counter interrupt enables and per-counter overflow flags.

Software loads each counter directly through its own address. A counter loaded with the two's-complement negative of a period wraps after that many increments. On that wrap the counter's overflow flag latches. The interrupt output stays high while any counter has both its flag and its interrupt enable set. Writing back the control word just read clears every flag that was set, because the flags are write-one-to-clear.

The register port is a single write port plus a combinational read port. Addresses: 0 is the control word, 1 is the cycle counter, 2 is counter 0 and 3 is counter 1.

Top module: `evmon_unit`

## Requirements
- R1: After reset, all three counters, the control word and irq_o are zero.
- R2: Control bits 31:28, 11, 7, 2 and 1 always read as 0. The other fields read back as stored: enable at bit 0, slow-down at bit 3, interrupt enables at 6:4, overflow flags at 10:8, counter 1 selector at 19:12, counter 0 selector at 27:20.
- R3: While the enable (bit 0) is 0, no counter changes except by a direct write or a zeroing command.
- R4: With the enable at 1 and bit 3 at 0, the cycle counter increments at every clock edge.
- R5: With bit 3 at 1, the cycle counter increments only at every 64th enabled edge. A 6-bit prescaler counts enabled edges from zero; the increment happens at the edge where the prescaler holds 63.
- R6: While enabled, counter 0 increments at each edge where evt_in[selector 0] is 1, and counter 1 does the same with selector 1. A selector value of NUM_EVT or more counts nothing.
- R7: Writing the control word with bit 2 at 1 zeroes the cycle counter and the prescaler. Writing it with bit 1 at 1 zeroes both event counters. Neither bit is stored.
- R8: A write to address 1, 2 or 3 loads the cycle counter, counter 0 or counter 1. A load takes priority over an increment in the same cycle and never sets a flag.
- R9: When an increment wraps a counter from all ones to zero, its overflow flag sets: bit 8 for counter 0, bit 9 for counter 1, bit 10 for the cycle counter.
- R10: A control write clears each overflow flag whose data bit is 1 and leaves flags with a 0 untouched. A wrap in the same cycle sets the flag anyway.
- R11: irq_o is 1 exactly while some flag and its matching interrupt enable are both 1: bit 4 for counter 0, bit 5 for counter 1, bit 6 for the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 cycle, 2 counter 0, 3 counter 1) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 32 | Combinational read data |
| evt_in | input | NUM_EVT | Single-cycle event pulses |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Every state change lands at the first rising edge after its stimulus: loads, zeroing commands, increments from a pulse held over that edge, and flag sets and clears. Both the read data and irq_o are combinational from those registers, so each result is due in the same clock period as that edge. The bench drives inputs on the falling edge, advances its reference model at the rising edge, and compares all four read addresses and irq_o on the following low phase. Every comparison therefore covers exactly one edge of effect. The slow cycle counter is checked over 140 edges, so both the 64th and the 128th enabled edge fall inside the window.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   // control word field positions (decoded by software, so fixed)
   localparam int unsigned CTL_W      = 32;
   localparam int unsigned SEL_W      = 8;
   localparam int unsigned B_RUN      = 0;
   localparam int unsigned B_ZEVT     = 1;
   localparam int unsigned B_ZCYC     = 2;
   localparam int unsigned B_SLOW     = 3;
   localparam int unsigned B_IEN_LO   = 4;
   localparam int unsigned B_OVF_LO   = 8;
   localparam int unsigned B_SEL1_LO  = 12;
   localparam int unsigned B_SEL0_LO  = 20;
   localparam int unsigned N_CNT      = 3;
   // counter slot order shared by enables and flags
   localparam int unsigned IX_EV0     = 0;
   localparam int unsigned IX_EV1     = 1;
   localparam int unsigned IX_CYC     = 2;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_CYC  = 2'd1,
      A_EV0  = 2'd2,
      A_EV1  = 2'd3
   } evmon_addr_e;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value <= '0;
      else if (load)   value <= load_val;
      else if (clr)    value <= '0;
      else if (inc)    value <= value + 1'b1;
   end

   assign wrap = inc && !load && !clr && (value == ALL_ONES);

   // R3: nothing but a command moves the count
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr && !load) |=> $stable(value));
   // R8: a load lands exactly
   a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (value == $past(load_val)));
endmodule

// File: rtl/evmon_prescale.sv
module evmon_prescale #(
   parameter int unsigned DIV_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV_LOG2 == 0) begin : g_bypass
         assign tick = run;
      end else begin : g_div
         logic [DIV_LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pre_q <= '0;
            else if (clr)  pre_q <= '0;
            else if (run)  pre_q <= pre_q + 1'b1;
         end
         assign tick = run && (pre_q == {DIV_LOG2{1'b1}});

         // R5: the prescaler only moves while running
         a_r5_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr) |=> $stable(pre_q));
      end
   endgenerate
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
   import evmon_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic [CTL_W-1:0] wdata,
   input  logic [N_CNT-1:0] wrap,
   output logic             run_en,
   output logic             slow_cyc,
   output logic [SEL_W-1:0] sel0,
   output logic [SEL_W-1:0] sel1,
   output logic             clr_cyc,
   output logic             clr_evt,
   output logic [CTL_W-1:0] ctrl_word,
   output logic             irq
);
   logic [N_CNT-1:0] ien_q;
   logic [N_CNT-1:0] ovf_q;
   logic [N_CNT-1:0] w1c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en   <= 1'b0;
         slow_cyc <= 1'b0;
         ien_q    <= '0;
         sel0     <= '0;
         sel1     <= '0;
      end else if (wr_ctrl) begin
         run_en   <= wdata[B_RUN];
         slow_cyc <= wdata[B_SLOW];
         ien_q    <= wdata[B_IEN_LO +: N_CNT];
         sel0     <= wdata[B_SEL0_LO +: SEL_W];
         sel1     <= wdata[B_SEL1_LO +: SEL_W];
      end
   end

   assign w1c = wr_ctrl ? wdata[B_OVF_LO +: N_CNT] : '0;

   // hardware set wins over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= (ovf_q & ~w1c) | wrap;
   end

   assign clr_cyc = wr_ctrl && wdata[B_ZCYC];
   assign clr_evt = wr_ctrl && wdata[B_ZEVT];
   assign irq     = |(ovf_q & ien_q);

   always_comb begin
      ctrl_word                          = '0;
      ctrl_word[B_RUN]                   = run_en;
      ctrl_word[B_SLOW]                  = slow_cyc;
      ctrl_word[B_IEN_LO +: N_CNT]       = ien_q;
      ctrl_word[B_OVF_LO +: N_CNT]       = ovf_q;
      ctrl_word[B_SEL1_LO +: SEL_W]      = sel1;
      ctrl_word[B_SEL0_LO +: SEL_W]      = sel0;
   end

   // R9: a wrap always leaves its flag set
   a_r9_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (|wrap) |=> ((ovf_q & $past(wrap)) == $past(wrap)));
   // R10: written ones clear flags absent a wrap
   a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wrap == '0) |=> ((ovf_q & $past(wdata[B_OVF_LO +: N_CNT])) == '0));
   // R11: an enabled wrap raises the interrupt
   a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctrl && |(wrap & ien_q)) |=> irq);
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
   import evmon_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned NUM_EVT  = 16,
   parameter int unsigned DIV_LOG2 = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [1:0]         rd_addr,
   output logic [31:0]        rd_data,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               irq_o
);
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   generate
      if (CNT_W < 2 || CNT_W > CTL_W) begin : g_bad_w
         $error("evmon_unit: CNT_W must lie in 2..32");
      end
      if (NUM_EVT < 1 || NUM_EVT > SEL_SPAN) begin : g_bad_evt
         $error("evmon_unit: NUM_EVT must lie in 1..256");
      end
      if (DIV_LOG2 > 16) begin : g_bad_div
         $error("evmon_unit: DIV_LOG2 too large");
      end
   endgenerate

   logic               wr_ctrl;
   logic               run_en, slow_cyc, clr_cyc, clr_evt, cyc_tick;
   logic [SEL_W-1:0]   sel0, sel1;
   logic [CTL_W-1:0]   ctrl_word;
   logic [SEL_SPAN-1:0] evt_pad;
   logic [N_CNT-1:0]   inc, clr, load, wrap;
   logic [CNT_W-1:0]   cnt_val [N_CNT];

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

   evmon_ctrl u_ctrl (
      .clk, .rst_n, .wr_ctrl, .wdata(wr_data), .wrap,
      .run_en, .slow_cyc, .sel0, .sel1, .clr_cyc, .clr_evt,
      .ctrl_word, .irq(irq_o)
   );

   evmon_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk, .rst_n, .run(run_en && slow_cyc), .clr(clr_cyc), .tick(cyc_tick)
   );

   // unselected selector values land on tied-off zero lines
   generate
      if (NUM_EVT == SEL_SPAN) begin : g_full
         assign evt_pad = evt_in;
      end else begin : g_pad
         assign evt_pad = {{(SEL_SPAN-NUM_EVT){1'b0}}, evt_in};
      end
   endgenerate

   assign inc[IX_EV0] = run_en && evt_pad[sel0];
   assign inc[IX_EV1] = run_en && evt_pad[sel1];
   assign inc[IX_CYC] = run_en && (slow_cyc ? cyc_tick : 1'b1);
   assign clr[IX_EV0] = clr_evt;
   assign clr[IX_EV1] = clr_evt;
   assign clr[IX_CYC] = clr_cyc;
   assign load[IX_EV0] = wr_en && (wr_addr == A_EV0);
   assign load[IX_EV1] = wr_en && (wr_addr == A_EV1);
   assign load[IX_CYC] = wr_en && (wr_addr == A_CYC);

   generate
      for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
         evmon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk, .rst_n, .inc(inc[i]), .clr(clr[i]), .load(load[i]),
            .load_val(wr_data[CNT_W-1:0]), .value(cnt_val[i]), .wrap(wrap[i])
         );
      end
   endgenerate

   always_comb begin
      unique case (rd_addr)
         A_CTRL:  rd_data = ctrl_word;
         A_CYC:   rd_data = 32'(cnt_val[IX_CYC]);
         A_EV0:   rd_data = 32'(cnt_val[IX_EV0]);
         default: rd_data = 32'(cnt_val[IX_EV1]);
      endcase
   end

   // R2: reserved and command bits never read back set
   a_r2_wz: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_CTRL) |-> (rd_data[31:28] == 4'd0 && !rd_data[11] &&
                                !rd_data[7] && rd_data[2:1] == 2'd0));
   // R7: cycle zeroing command empties the cycle counter
   a_r7_cyc_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wr_data[B_ZCYC]) |=> (cnt_val[IX_CYC] == '0));
   // R7: event zeroing command empties both event counters
   a_r7_evt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wr_data[B_ZEVT]) |=> (cnt_val[IX_EV0] == '0 && cnt_val[IX_EV1] == '0));
endmodule

// File: tb/sim_evmon_unit.sv
module sim_evmon_unit;
   localparam int NEV = 16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0] rd_addr = 2'd0;
   logic [31:0] rd_data;
   logic [NEV-1:0] evt_in = '0;
   logic irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   evmon_unit #(.CNT_W(32), .NUM_EVT(NEV), .DIV_LOG2(6)) u0 (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .evt_in, .irq_o
   );

   // reference state
   logic m_e, m_d;
   logic [2:0] m_ien, m_ovf;
   logic [7:0] m_s0, m_s1;
   logic [31:0] m_cyc, m_c0, m_c1;
   logic [5:0] m_pre;

   function automatic logic [31:0] m_ctrl();
      return {4'b0, m_s0, m_s1, 1'b0, m_ovf, 1'b0, m_ien, m_d, 2'b00, m_e};
   endfunction

   function automatic logic ev_hit(logic [7:0] s, logic [NEV-1:0] ev);
      if (s >= NEV) return 1'b0;
      return ev[s[3:0]];
   endfunction

   task automatic m_reset();
      m_e = 0; m_d = 0; m_ien = 0; m_ovf = 0; m_s0 = 0; m_s1 = 0;
      m_cyc = 0; m_c0 = 0; m_c1 = 0; m_pre = 0;
   endtask

   // one rising edge of the reference, using the pre-edge inputs
   task automatic m_step();
      logic wc, zc, ze, i0, i1, ic;
      logic [2:0] wr3, clr3;
      wc = wr_en && wr_addr == 2'd0;
      zc = wc && wr_data[2];
      ze = wc && wr_data[1];
      i0 = m_e && ev_hit(m_s0, evt_in);
      i1 = m_e && ev_hit(m_s1, evt_in);
      ic = m_e && (!m_d || m_pre == 6'd63);
      wr3 = 3'b000;
      clr3 = wc ? wr_data[10:8] : 3'b000;
      if (wr_en && wr_addr == 2'd2) m_c0 = wr_data;
      else if (ze) m_c0 = 0;
      else if (i0) begin wr3[0] = (m_c0 == 32'hFFFF_FFFF); m_c0 = m_c0 + 1; end
      if (wr_en && wr_addr == 2'd3) m_c1 = wr_data;
      else if (ze) m_c1 = 0;
      else if (i1) begin wr3[1] = (m_c1 == 32'hFFFF_FFFF); m_c1 = m_c1 + 1; end
      if (wr_en && wr_addr == 2'd1) m_cyc = wr_data;
      else if (zc) m_cyc = 0;
      else if (ic) begin wr3[2] = (m_cyc == 32'hFFFF_FFFF); m_cyc = m_cyc + 1; end
      if (zc) m_pre = 0;
      else if (m_e && m_d) m_pre = m_pre + 1;
      m_ovf = (m_ovf & ~clr3) | wr3;
      if (wc) begin
         m_e = wr_data[0]; m_d = wr_data[3]; m_ien = wr_data[6:4];
         m_s0 = wr_data[27:20]; m_s1 = wr_data[19:12];
      end
   endtask

   task automatic chk(string req, string ph, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) t=%0t actual=%h expected=%h", req, ph, $time, act, exp);
      end
   endtask

   // on the low phase: compare all read addresses and the interrupt
   task automatic check_all(string ph);
      rd_addr = 2'd0; #1 chk("R2", ph, rd_data, m_ctrl());
      rd_addr = 2'd1; #1 chk("R4", ph, rd_data, m_cyc);
      rd_addr = 2'd2; #1 chk("R6", ph, rd_data, m_c0);
      rd_addr = 2'd3; #1 chk("R6", ph, rd_data, m_c1);
      chk("R11", ph, {31'b0, irq_o}, {31'b0, |(m_ovf & m_ien)});
   endtask

   task automatic tick(string ph);
      @(posedge clk);
      m_step();
      @(negedge clk);
      wr_en = 1'b0;
      check_all(ph);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d, string ph);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(ph);
   endtask

   task automatic idle(int n, logic [NEV-1:0] ev, string ph);
      for (int k = 0; k < n; k++) begin
         evt_in = ev;
         tick(ph);
      end
      evt_in = '0;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      check_all("R1");

      // R2: all ones written, reserved and command bits read 0
      wr(2'd0, 32'hFFFF_FFFF, "R2");
      // R3: disabled, events and time pass without counting
      wr(2'd0, 32'h0000_0070, "R3");
      idle(8, '1, "R3");
      // R4: full-rate cycle counting after zeroing
      wr(2'd0, 32'h0000_0007, "R4");
      idle(10, '0, "R4");
      // R5: slow cycle counting, prescaler zeroed
      wr(2'd0, 32'h0000_000D, "R5");
      idle(140, '0, "R5");
      // R6: counter 0 on line 3, counter 1 on an absent line
      wr(2'd0, 32'h0031_5003, "R6");
      for (int k = 0; k < 40; k++) idle(1, NEV'($urandom), "R6");
      wr(2'd0, 32'h0035_A003, "R6 sel");
      for (int k = 0; k < 40; k++) idle(1, NEV'($urandom), "R6 both");
      // R8/R9: preload near wrap with interrupts enabled
      wr(2'd0, 32'h0030_4071, "R9 cfg");
      wr(2'd2, 32'hFFFF_FFFD, "R8");
      wr(2'd3, 32'hFFFF_FFFE, "R8");
      wr(2'd1, 32'hFFFF_FFFC, "R8");
      idle(5, 16'h0018, "R9");
      // R8: load during an increment wins, no flag from load
      evt_in = 16'h0008;
      wr(2'd2, 32'hFFFF_FFFF, "R8 race");
      evt_in = '0;
      // R10: clear only counter 1 flag, then all
      wr(2'd0, 32'h0030_4271, "R10");
      wr(2'd0, 32'h0030_4771, "R10");
      // R10: flag set and clear in the same edge
      wr(2'd1, 32'hFFFF_FFFF, "R10 prep");
      wr(2'd0, 32'h0030_4471, "R10 race");
      // R7: zero cycle counter only, then events only
      wr(2'd0, 32'h0030_4075, "R7");
      idle(3, '0, "R7");
      wr(2'd0, 32'h0030_4073, "R7");

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] r;
         r = $urandom;
         evt_in = NEV'($urandom);
         if (r[2:0] == 3'd0) begin
            wr_en = 1'b1;
            wr_addr = r[4:3];
            if (r[4:3] == 2'd0) begin
               wr_data = $urandom;
               wr_data[27:20] = 8'($urandom_range(0, 19));
               wr_data[19:12] = 8'($urandom_range(0, 19));
               wr_data[0] = (r[7:5] != 3'd0);
               wr_data[3] = (r[10:8] == 3'd0);
               wr_data[2:1] = (r[13:11] == 3'd0) ? r[15:14] : 2'b00;
            end else begin
               wr_data = 32'hFFFF_FF00 | 32'($urandom_range(0, 255));
            end
         end
         tick("R9 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule